// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a clocked single-port memory for a processor's cache or local store. The address, the chip select and strobe controls, the write controls and the write data are all taken on the rising clock edge. The read path has no output register. The word at the current burst address flows combinationally from the array to `dout` during the cycle that follows the sampling edge. A burst therefore takes two cycles for its first beat and one cycle for each later beat.

A burst starts when either of two start strobes loads a new address. One strobe comes from the processor and the other from the cache controller. An internal 2-bit beat counter then supplies three more addresses when the advance input is held low. The low two address bits follow either a linear sequence or an interleaved sequence, chosen by an order-select pin.

Writes use the same address sequence. A global write stores the whole word. A byte-write enable stores only the bytes picked by four byte selects. An asynchronous output enable and a sleep input gate the data-bus driver enable. The depth is a parameter: setting `AW` to 15 gives the full 32768 x 32 organisation, and a smaller default keeps elaboration light.

Top module: `flowsram_top`

## Requirements
- R1: An edge with `adsc_n` low, `adsp_n` high and the chip selected (`ce_n` low, `cs0` high, `cs1_n` low) loads `addr`. During the following cycle `dout` shows the stored word at `addr`, and `dq_oe` is high when the cycle is a read and `oe_n` is low.
- R2: With `ilv_order` low, each edge with `adv_n` low and no start strobe moves to the next beat. The low two address bits are the loaded bits plus the beat count, modulo 4. The beat count wraps after 3, and the upper address bits never change within a burst.
- R3: With `ilv_order` high, the low two address bits are the loaded bits XOR the beat count (0, 1, 2, 3 in turn).
- R4: An edge with `adv_n` high and no start strobe keeps the current burst address.
- R5: `gw_n` low on a write-capable edge stores all 32 bits of `din` at the address set up by that edge.
- R6: With `gw_n` high and `bwe_n` low, only the bytes whose `bw_n` bit is low are written. `bw_n[0]` covers bits 7:0, and `bw_n[3]` covers bits 31:24.
- R7: With `gw_n` and `bwe_n` both high, or with `bwe_n` low and every `bw_n` bit high, the array is left unchanged.
- R8: `adsp_n` has no effect while `ce_n` is high, so a running burst carries on and an idle device stays idle. When `ce_n` is low, `adsp_n` takes priority over `adsc_n`. An edge started by `adsp_n` never writes.
- R9: A start strobe seen while the chip is not selected ends any burst. After that, `dq_oe` stays low, and advance or write edges have no effect until a new burst starts.
- R10: `oe_n` acts without a clock: raising it drops `dq_oe` at once, and lowering it restores `dq_oe`.
- R11: `sleep` high drops `dq_oe` at once. An edge taken while `sleep` is high writes nothing and ends the burst. The array keeps its contents.
- R12: While `rst_n` is low, and after it rises, `dq_oe` is low until a burst is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address |
| ce_n | input | 1 | Chip enable, active low; also qualifies `adsp_n` |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor start strobe, active low |
| adsc_n | input | 1 | Cache-controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global whole-word write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Byte selects, active low, bit 0 = bits 7:0 |
| ilv_order | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down: drivers off, contents kept |
| din | input | 32 | Write data |
| dout | output | 32 | Flow-through read data |
| dq_oe | output | 1 | Data-bus driver enable |

## Verification
The assertions assume that the control inputs settle before each rising edge. They also assume that `addr` is a valid word index and that `ilv_order` stays constant within a burst. The bench changes inputs only one time unit after an edge and keeps the order pin fixed for the length of each burst. The bench fills every word, then sweeps bursts from every start address in both orders against a model array that it keeps itself. The byte-select patterns, strobe conflicts, deselects, sleep and output-enable cases are covered by directed sequences.

// File: rtl/flowsram_pkg.sv
// Shared types and the burst address helper for the flow-through SRAM.
// Assumes a burst of four beats addressed through the low two bits.
package flowsram_pkg;

    // What the sampling edge does to the access state.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_DESEL,
        OP_STEP,
        OP_HOLD,
        OP_SLEEP
    } edge_op_t;

    // Low two address bits for a given beat in linear or interleaved order.
    function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                           input logic [1:0] beat,
                                           input logic       ilv);
        return ilv ? (base ^ beat) : (base + beat);
    endfunction

endpackage

// File: rtl/flowsram_ctrl.sv
// Input-side control of the SRAM. It decodes the strobes, selects and
// write controls for each edge and keeps the burst base and beat count.
// It produces the write port request and the registered current address.
// Assumes the inputs are stable at the rising edge of clk.
module flowsram_ctrl
    import flowsram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          cs0,
    input  logic          cs1_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          ilv_order,
    input  logic          sleep,
    output logic [AW-1:0] wr_addr,
    output logic [NB-1:0] wr_mask,
    output logic [AW-1:0] cur_addr,
    output logic          busy,
    output logic          rd_cyc
);

    logic [AW-1:0] base_q, nxt_base;
    logic [1:0]    beat_q, nxt_beat;
    logic          load_p, load_c, chip_sel, nxt_busy, wr_ok;
    logic [NB-1:0] byte_sel;
    edge_op_t      op;

    // Classify the coming edge from the strobes, the selects and the state.
    always_comb begin
        load_p   = !adsp_n && !ce_n;
        load_c   = !adsc_n && !load_p;
        chip_sel = !ce_n && cs0 && !cs1_n;
        if (sleep)                op = OP_SLEEP;
        else if (load_p || load_c) op = chip_sel ? OP_LOAD : OP_DESEL;
        else if (busy)            op = adv_n ? OP_HOLD : OP_STEP;
        else                      op = OP_IDLE;
    end

    // Next base, beat and address of the burst counter.
    always_comb begin
        nxt_base = (op == OP_LOAD) ? addr : base_q;
        case (op)
            OP_LOAD: nxt_beat = 2'd0;
            OP_STEP: nxt_beat = beat_q + 2'd1;
            default: nxt_beat = beat_q;
        endcase
        nxt_busy = (op == OP_LOAD) || (op == OP_STEP) || (op == OP_HOLD);
        wr_addr  = {nxt_base[AW-1:2], beat_lo(nxt_base[1:0], nxt_beat, ilv_order)};
    end

    // Byte write request: a whole word, a byte subset, or nothing.
    always_comb begin
        if (!gw_n)       byte_sel = '1;
        else if (!bwe_n) byte_sel = ~bw_n;
        else             byte_sel = '0;
        wr_ok   = nxt_busy && !load_p;
        wr_mask = wr_ok ? byte_sel : '0;
    end

    // Register the burst state and the address that the read path uses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            beat_q   <= '0;
            cur_addr <= '0;
            busy     <= 1'b0;
            rd_cyc   <= 1'b0;
        end else begin
            base_q   <= nxt_base;
            beat_q   <= nxt_beat;
            cur_addr <= wr_addr;
            busy     <= nxt_busy;
            rd_cyc   <= nxt_busy && (wr_mask == '0);
        end
    end

endmodule

// File: rtl/flowsram_array.sv
// Storage array with byte-granular synchronous write and an unregistered
// read. Assumes a single write port and a read address held stable by the
// control registers. The contents are not reset.
module flowsram_array #(
    parameter int AW = 8,
    parameter int NB = 4,
    localparam int DW    = NB * 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic [AW-1:0] wr_addr,
    input  logic [NB-1:0] wr_mask,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store the selected bytes of the write word.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (wr_mask[b]) mem[wr_addr][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    // Flow-through read of the current address.
    always_comb rdata = mem[rd_addr];

endmodule

// File: rtl/flowsram_drv.sv
// Output driver enable. It combines the asynchronous output enable and the
// sleep input with the registered read state. Assumes oe_n and sleep may
// change at any time.
module flowsram_drv (
    input  logic oe_n,
    input  logic sleep,
    input  logic busy,
    input  logic rd_cyc,
    output logic dq_oe
);

    // Drive only for an active read cycle that is neither masked nor asleep.
    always_comb dq_oe = !oe_n && !sleep && busy && rd_cyc;

endmodule

// File: rtl/flowsram_top.sv
// Flow-through synchronous burst SRAM. Inputs are taken at the clock edge,
// read data flows from the array without an output register, and a 2-bit
// beat counter supplies linear or interleaved burst addresses.
// Assumes one clock domain and a synchronous active-low reset.
module flowsram_top #(
    parameter int AW = 8,
    localparam int NB = 4,
    localparam int DW = NB * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          cs0,
    input  logic          cs1_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          ilv_order,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dq_oe
);

    logic [AW-1:0] wr_addr, cur_addr;
    logic [NB-1:0] wr_mask;
    logic          busy, rd_cyc;

    flowsram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs0(cs0),
        .cs1_n(cs1_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .ilv_order(ilv_order),
        .sleep(sleep), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .cur_addr(cur_addr), .busy(busy), .rd_cyc(rd_cyc)
    );

    flowsram_array #(.AW(AW), .NB(NB)) u_array (
        .clk(clk), .wr_addr(wr_addr), .wr_mask(wr_mask), .wdata(din),
        .rd_addr(cur_addr), .rdata(dout)
    );

    flowsram_drv u_drv (
        .oe_n(oe_n), .sleep(sleep), .busy(busy), .rd_cyc(rd_cyc),
        .dq_oe(dq_oe)
    );

endmodule

// File: rtl/flowsram_chk.sv
// Protocol checker for flowsram_top, attached by bind. It observes the
// control inputs together with the burst state and the current address.
module flowsram_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          ce_n,
    input logic          cs0,
    input logic          cs1_n,
    input logic          adsp_n,
    input logic          adsc_n,
    input logic          adv_n,
    input logic          sleep,
    input logic          busy,
    input logic [AW-1:0] cur_addr
);

    // R1: a selected cache-controller start loads the sampled address
    a_r1_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsc_n && adsp_n && !ce_n && cs0 && !cs1_n && !sleep)
        |=> (busy && cur_addr == $past(addr)));

    // R2: upper address bits stay put while a burst advances
    a_r2_hi_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adsc_n && (adsp_n || ce_n) && !adv_n && !sleep)
        |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    // R4: without advance the burst address holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adsc_n && (adsp_n || ce_n) && adv_n && !sleep)
        |=> $stable(cur_addr));

    // R8: processor strobe with chip enable high cannot start an idle device
    a_r8_adsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !adsp_n && ce_n && adsc_n && !sleep) |=> !busy);

    // R9: a start strobe while not selected ends the burst
    a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsc_n && adsp_n && (ce_n || !cs0 || cs1_n) && !sleep) |=> !busy);

    // R11: an edge taken asleep ends the burst
    a_r11_sleep_ends: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !busy);

endmodule

bind flowsram_top flowsram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs0(cs0),
    .cs1_n(cs1_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .sleep(sleep), .busy(busy), .cur_addr(cur_addr)
);

// File: tb/flowsram_top_bench.sv
module flowsram_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, cs0, cs1_n, adsp_n, adsc_n, adv_n;
    logic          gw_n, bwe_n, ilv_order, oe_n, sleep, dq_oe;
    logic [3:0]    bw_n;
    logic [AW-1:0] addr;
    logic [31:0]   din, dout;
    logic [31:0]   model [DEPTH];
    int            n_tests = 0, n_fail = 0;
    bit            done = 0;

    flowsram_top #(.AW(AW)) u_flowsram_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs0(cs0),
        .cs1_n(cs1_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .ilv_order(ilv_order),
        .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dq_oe(dq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        ce_n = 0; cs0 = 1; cs1_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; sleep = 0; oe_n = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] pat(input int a, input int salt);
        return 32'h9E37_79B9 * (a + 1) + 32'h0101_0101 * salt;
    endfunction

    function automatic int burst_addr(input int base, input int beat, input logic ilv);
        int lo;
        lo = ilv ? ((base & 3) ^ beat) : (((base & 3) + beat) & 3);
        return (base & ~3) | lo;
    endfunction

    // Start a read burst with the cache-controller strobe and check beat 0.
    task automatic start_read(input int a, input logic ilv, input string req);
        set_idle(); ilv_order = ilv; addr = AW'(a); adsc_n = 0;
        tick();
        check(req, dout, model[a]);
        check(req, 32'(dq_oe), 32'd1);
        set_idle();
    endtask

    // Advance one beat and check the word and the driver enable.
    task automatic step_read(input int exp_a, input string req);
        set_idle(); adv_n = 0;
        tick();
        check(req, dout, model[exp_a]);
        check(req, 32'(dq_oe), 32'd1);
        set_idle();
    endtask

    initial begin
        set_idle(); ilv_order = 0; addr = '0; din = '0; rst_n = 0;
        // R12: held reset keeps the driver off
        tick(); tick();
        check("R12", 32'(dq_oe), 32'd0);
        rst_n = 1;
        tick();
        check("R12", 32'(dq_oe), 32'd0);

        // R5: fill every word with a whole-word write
        for (int a = 0; a < DEPTH; a++) begin
            set_idle(); addr = AW'(a); adsc_n = 0; gw_n = 0; din = pat(a, 0);
            tick();
            model[a] = pat(a, 0);
        end
        set_idle();

        // R1 R2 R3: bursts from every start address in both orders
        for (int o = 0; o < 2; o++) begin
            for (int a = 0; a < DEPTH; a++) begin
                start_read(a, o[0], "R1");
                for (int i = 1; i < 4; i++)
                    step_read(burst_addr(a, i, o[0]), o[0] ? "R3" : "R2");
            end
        end

        // R2: beat count wraps after the fourth beat
        start_read(6, 1'b0, "R1");
        step_read(7, "R2"); step_read(4, "R2"); step_read(5, "R2"); step_read(6, "R2");

        // R4: hold keeps the address, then advance resumes
        start_read(41, 1'b0, "R1");
        step_read(42, "R2");
        set_idle(); tick(); check("R4", dout, model[42]);
        tick();             check("R4", dout, model[42]);
        step_read(43, "R4");

        // R5: interleaved write burst from base 65 (65, 64, 67, 66)
        ilv_order = 1;
        set_idle(); addr = AW'(65); adsc_n = 0; gw_n = 0; din = pat(65, 7);
        tick(); model[65] = pat(65, 7);
        for (int i = 1; i < 4; i++) begin
            set_idle(); adv_n = 0; gw_n = 0; din = pat(burst_addr(65, i, 1'b1), 7);
            tick(); model[burst_addr(65, i, 1'b1)] = pat(burst_addr(65, i, 1'b1), 7);
            check("R5", 32'(dq_oe), 32'd0);
        end
        start_read(65, 1'b1, "R5");
        for (int i = 1; i < 4; i++) step_read(burst_addr(65, i, 1'b1), "R5");

        // R6: each byte-select pattern writes only the selected bytes
        for (int m = 0; m < 16; m++) begin
            logic [31:0] nd, keep;
            nd = pat(m, 9);
            keep = model[100];
            set_idle(); addr = AW'(100); adsc_n = 0; bwe_n = 0; bw_n = 4'(m); din = nd;
            tick();
            for (int b = 0; b < 4; b++)
                if (!m[b]) keep[b*8 +: 8] = nd[b*8 +: 8];
            model[100] = keep;
            start_read(100, 1'b0, "R6");
        end

        // R7: write controls inactive leave the word unchanged
        set_idle(); addr = AW'(101); adsc_n = 0; din = 32'hFFFF_0000;
        tick();
        start_read(101, 1'b0, "R7");
        set_idle(); addr = AW'(101); adsc_n = 0; bwe_n = 0; bw_n = 4'hF; din = 32'h1234_5678;
        tick();
        start_read(101, 1'b0, "R7");

        // R8: processor strobe ignored with chip enable high, burst continues
        start_read(16, 1'b0, "R1");
        set_idle(); ce_n = 1; adsp_n = 0; adv_n = 0; addr = AW'(99);
        tick();
        check("R8", dout, model[17]);
        check("R8", 32'(dq_oe), 32'd1);
        // R8: processor-started cycle never writes, and wins over adsc_n
        set_idle(); adsp_n = 0; adsc_n = 0; addr = AW'(20); gw_n = 0; din = 32'hBAD0_BAD0;
        tick();
        check("R8", dout, model[20]);
        check("R8", 32'(dq_oe), 32'd1);
        start_read(20, 1'b0, "R8");

        // R9: deselect by each select input ends the burst
        for (int k = 0; k < 3; k++) begin
            start_read(30, 1'b0, "R1");
            set_idle(); adsc_n = 0; addr = AW'(50);
            if (k == 0) cs0 = 0; else if (k == 1) cs1_n = 1; else ce_n = 1;
            tick();
            check("R9", 32'(dq_oe), 32'd0);
            set_idle(); adv_n = 0; gw_n = 0; din = 32'hDEAD_0000;
            tick();
            check("R9", 32'(dq_oe), 32'd0);
        end
        start_read(31, 1'b0, "R9");
        start_read(50, 1'b0, "R9");
        // R8: idle device stays idle on an ignored processor strobe
        set_idle(); adsc_n = 0; cs0 = 0; tick();
        set_idle(); ce_n = 1; adsp_n = 0; addr = AW'(10);
        tick();
        check("R8", 32'(dq_oe), 32'd0);

        // R10: output enable acts between clock edges
        start_read(12, 1'b0, "R1");
        oe_n = 1; #2;
        check("R10", 32'(dq_oe), 32'd0);
        oe_n = 0; #2;
        check("R10", 32'(dq_oe), 32'd1);

        // R11: sleep drops drivers, blocks writes, ends the burst, keeps data
        tick();
        sleep = 1; #1;
        check("R11", 32'(dq_oe), 32'd0);
        adsc_n = 0; addr = AW'(5); gw_n = 0; din = 32'h5555_AAAA;
        tick();
        check("R11", 32'(dq_oe), 32'd0);
        set_idle(); adv_n = 0;
        tick();
        check("R11", 32'(dq_oe), 32'd0);
        start_read(5, 1'b0, "R11");
        start_read(12, 1'b0, "R11");

        // R12: reset in the middle of a burst turns the driver off
        start_read(70, 1'b0, "R1");
        rst_n = 0;
        tick();
        check("R12", 32'(dq_oe), 32'd0);
        rst_n = 1;
        tick();
        check("R12", 32'(dq_oe), 32'd0);

        finish_run();
    end

endmodule